// File: doc/BRIEF.md
# Transition-Minimizing Bus Inversion Codec

This block reduces switching activity on a wide parallel data bus. The transmit side accepts a data word with a valid strobe. It splits the word into equal lanes and compares each lane with the wire values that lane drove last. When more than half of a lane's wires would toggle, the lane is sent complemented and its inversion flag is raised.

The wire word, the flags and a wire-valid strobe come out of registers one cycle after the input is accepted. Between accepted words the wires hold their last values. The receive side is purely combinational. It takes a wire word and its flags, and complements each flagged lane to restore the original data.

Top module: `dbi_codec`

## Requirements
- R1: Lane k covers data bits [16k+15:16k] (k = 0..3) and is governed only by flag bit k of `tx_inv` / `rx_inv`.
- R2: A lane is sent inverted (flag 1) when its candidate data differs from that lane's held wire value in more than 8 of 16 bits.
- R3: A lane whose candidate data differs from the held wire value in exactly 8 bits (or fewer) is sent true (flag 0).
- R4: For each accepted word, each lane of `tx_wire` equals that lane's input data XOR its flag replicated over 16 bits.
- R5: While reset is high and after reset, the held wire word is all zeros, all flags are 0 and `tx_wire_vld` is 0.
- R6: In a cycle where `tx_vld` is low, `tx_wire` and `tx_inv` keep their values in the next cycle, and `tx_wire_vld` is 0 in the next cycle.
- R7: `tx_wire_vld` is high exactly one cycle after a cycle where `tx_vld` is high, with the encoded word on `tx_wire`.
- R8: `rx_data` lane k equals `rx_wire` lane k XOR `rx_inv[k]` replicated, in the same cycle with no clock.
- R9: For every accepted word, no lane of `tx_wire` toggles more than 8 of its 16 wires against its previous value. The flag toggle is not counted.
- R10: Feeding `tx_wire`/`tx_inv` back into `rx_wire`/`rx_inv` returns the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_vld | input | 1 | Transmit word valid |
| tx_data | input | 64 | Transmit data word |
| tx_wire | output | 64 | Registered wire word, possibly lane-inverted |
| tx_inv | output | 4 | Registered per-lane inversion flags |
| tx_wire_vld | output | 1 | Wire word valid, one cycle after `tx_vld` |
| rx_wire | input | 64 | Received wire word |
| rx_inv | input | 4 | Received per-lane inversion flags |
| rx_data | output | 64 | Restored data word |

## Verification
The bench builds the codec with its default values: four lanes of 16 bits. At that size, exact threshold patterns can be placed in one lane while the other lanes stay quiet. Those patterns are 9 differing bits for inversion and 8 for the tie. The four-lane layout also lets a single-lane stimulus confirm that each flag maps to its own slice. Long random streams with loopback into the decoder exercise the held-state chaining between words, including inverted held values.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int DBI_LANE_W_DEF = 16;
  localparam int DBI_LANES_DEF  = 4;
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] cand,
  input  logic [LW-1:0] held,
  output logic          inv,
  output logic [LW-1:0] drive
);
  localparam int CW   = $clog2(LW + 1);
  localparam int HALF = LW / 2;

  logic [LW-1:0] diff;
  logic [CW-1:0] toggles;

  always_comb begin
    diff    = cand ^ held;
    toggles = '0;
    for (int i = 0; i < LW; i++) toggles = toggles + CW'(diff[i]);
    inv   = (toggles > CW'(HALF));
    drive = inv ? ~cand : cand;
  end
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] wire_in,
  input  logic          flag,
  output logic [LW-1:0] data_out
);
  always_comb data_out = wire_in ^ {LW{flag}};
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int LANE_W = DBI_LANE_W_DEF,
  parameter int LANES  = DBI_LANES_DEF,
  localparam int DW    = LANE_W * LANES,
  localparam int HALF  = LANE_W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_vld,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] tx_wire,
  output logic [LANES-1:0] tx_inv,
  output logic          tx_wire_vld,
  input  logic [DW-1:0] rx_wire,
  input  logic [LANES-1:0] rx_inv,
  output logic [DW-1:0] rx_data
);
  logic [DW-1:0]    wire_q, wire_nxt;
  logic [LANES-1:0] inv_q, inv_nxt;
  logic             vld_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dbi_lane_enc #(.LW(LANE_W)) u_enc (
      .cand (tx_data[g*LANE_W +: LANE_W]),
      .held (wire_q[g*LANE_W +: LANE_W]),
      .inv  (inv_nxt[g]),
      .drive(wire_nxt[g*LANE_W +: LANE_W])
    );
    dbi_lane_dec #(.LW(LANE_W)) u_dec (
      .wire_in (rx_wire[g*LANE_W +: LANE_W]),
      .flag    (rx_inv[g]),
      .data_out(rx_data[g*LANE_W +: LANE_W])
    );

    // Inversion above half, true at or below half (R2, R3)
    assert_invert_R2: assert property (@(posedge clk) disable iff (rst)
      tx_wire_vld && ($countones($past(tx_data[g*LANE_W +: LANE_W]) ^
                                 $past(tx_wire[g*LANE_W +: LANE_W])) > HALF)
      |-> tx_inv[g]);
    assert_tie_true_R3: assert property (@(posedge clk) disable iff (rst)
      tx_wire_vld && ($countones($past(tx_data[g*LANE_W +: LANE_W]) ^
                                 $past(tx_wire[g*LANE_W +: LANE_W])) <= HALF)
      |-> !tx_inv[g]);
    assert_toggle_limit_R9: assert property (@(posedge clk) disable iff (rst)
      tx_wire_vld |-> ($countones(tx_wire[g*LANE_W +: LANE_W] ^
                                  $past(tx_wire[g*LANE_W +: LANE_W])) <= HALF));
    assert_flag_meaning_R4: assert property (@(posedge clk) disable iff (rst)
      tx_wire_vld |-> ((tx_wire[g*LANE_W +: LANE_W] ^ {LANE_W{tx_inv[g]}}) ==
                       $past(tx_data[g*LANE_W +: LANE_W])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wire_q <= '0;
      inv_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= tx_vld;
      if (tx_vld) begin
        wire_q <= wire_nxt;
        inv_q  <= inv_nxt;
      end
    end
  end

  assign tx_wire     = wire_q;
  assign tx_inv      = inv_q;
  assign tx_wire_vld = vld_q;

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_vld |=> ($stable(tx_wire) && $stable(tx_inv) && !tx_wire_vld));
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    tx_vld |=> tx_wire_vld);
endmodule

// File: tb/sim_dbi_codec.sv
module sim_dbi_codec;
  localparam int LW = 16;
  localparam int NL = 4;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_vld = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic [DW-1:0] tx_wire;
  logic [NL-1:0] tx_inv;
  logic tx_wire_vld;
  logic [DW-1:0] rx_wire = '0;
  logic [NL-1:0] rx_inv = '0;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_wire;
  logic [NL-1:0] m_inv;

  always #2 clk = ~clk;

  dbi_codec u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference encoder from requirements R2/R3/R4
  task automatic model_step(input logic [DW-1:0] d);
    for (int k = 0; k < NL; k++) begin
      logic [LW-1:0] c;
      int n;
      c = d[k*LW +: LW];
      n = $countones(c ^ m_wire[k*LW +: LW]);
      m_inv[k] = (n > LW/2);
      m_wire[k*LW +: LW] = m_inv[k] ? ~c : c;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tx_vld = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_wire = '0; m_inv = '0;
  endtask

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk); tx_vld = 1'b1; tx_data = d;
    model_step(d);
    @(negedge clk); tx_vld = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(tx_wire == '0, "R5 wire", tx_wire, '0);
    chk(tx_inv == '0 && !tx_wire_vld, "R5 flags/vld", {tx_inv, 3'b0, tx_wire_vld}, '0);
  endtask

  task automatic t_lane_map();
    do_reset();
    send(64'h0000_0000_0000_FFFF);
    chk(tx_inv == 4'b0001, "R1 lane0 flag", DW'(tx_inv), 64'h1);
    chk(tx_wire == '0, "R1 lane0 wire", tx_wire, '0);
    send(64'hFFFF_0000_0000_0000);
    chk(tx_inv == 4'b1000, "R1 lane3 flag", DW'(tx_inv), 64'h8);
  endtask

  task automatic t_threshold();
    do_reset();
    send(64'h0000_0000_0000_01FF);
    chk(tx_inv == 4'b0001, "R2 nine toggles flag", DW'(tx_inv), 64'h1);
    chk(tx_wire == 64'h0000_0000_0000_FE00, "R4 inverted lane", tx_wire, 64'hFE00);
    chk(tx_wire_vld == 1'b1, "R7 valid after one cycle", DW'(tx_wire_vld), 64'h1);
    do_reset();
    send(64'h0000_0000_0000_00FF);
    chk(tx_inv == 4'b0000, "R3 eight toggles true", DW'(tx_inv), 64'h0);
    chk(tx_wire == 64'h0000_0000_0000_00FF, "R3 wire true", tx_wire, 64'hFF);
  endtask

  task automatic t_idle();
    logic [DW-1:0] w;
    logic [NL-1:0] f;
    do_reset();
    send(64'h1234_FFFF_00F0_ABCD);
    w = tx_wire; f = tx_inv;
    @(negedge clk); tx_data = ~64'h1234_FFFF_00F0_ABCD;
    @(negedge clk); @(negedge clk);
    chk(tx_wire == w && tx_inv == f, "R6 idle hold", tx_wire, w);
    chk(!tx_wire_vld, "R6 idle vld low", DW'(tx_wire_vld), '0);
  endtask

  task automatic t_decoder();
    rx_wire = 64'h0F0F_AAAA_1234_FFFF; rx_inv = 4'b1010; #1;
    chk(rx_data == 64'hF0F0_AAAA_EDCB_FFFF, "R8 decode", rx_data, 64'hF0F0_AAAA_EDCB_FFFF);
    rx_inv = 4'b0101; #1;
    chk(rx_data == 64'h0F0F_5555_1234_0000, "R8 decode alt", rx_data, 64'h0F0F_5555_1234_0000);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] d, prev;
      d = {$urandom, $urandom};
      if (i % 7 == 0) d = ~tx_wire;
      prev = tx_wire;
      send(d);
      chk(tx_wire == m_wire && tx_inv == m_inv, "R2 stream vs model", tx_wire, m_wire);
      for (int k = 0; k < NL; k++)
        chk($countones(tx_wire[k*LW +: LW] ^ prev[k*LW +: LW]) <= LW/2, "R9 toggle limit",
            tx_wire, prev);
      rx_wire = tx_wire; rx_inv = tx_inv; #1;
      chk(rx_data == d, "R10 round trip", rx_data, d);
    end
  endtask

  initial begin
    t_reset();
    t_lane_map();
    t_threshold();
    t_idle();
    t_decoder();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule